// File: doc/BRIEF.md
# Cell-Boundary Transmit Flow Controller

This controller sits between a first-word-fall-through transmit FIFO and a character encoder. On every clock, which is one character time, it either pops one FIFO entry and passes its payload on as a data character, or sends a special character. The special character is either the idle fill code or one of two interrupt codes. Each FIFO entry carries a payload and a start-of-cell flag.

Three external controls steer the flow. A cell-boundary stop lets the current cell drain and then parks in front of the next start-of-cell entry. An immediate halt freezes FIFO reads at once. An interrupt line is edge-sensitive: each of its transitions injects a one-slot interrupt character, and the data stream keeps going around it. The controls take effect only while the FIFO-enable input is high. When the encoder-bypass input is high, the halt pin and start-of-cell flags are disregarded, and the stop pin behaves as an immediate halt instead.

Top module: `txflow_ctrl`

## Requirements
- R1: While `fifo_en` is low, `stop_n`, `halt_n` and `intr` have no effect: every available entry is read and sent, and no interrupt character is emitted.
- R2: With `stop_n` low and bypass off, entries whose start-of-cell flag is 0 keep being read and sent. An entry at the FIFO head whose flag is 1 is not read, and the fill character is sent in its place.
- R3: A single clock of `stop_n` high while a start-of-cell entry waits at the head releases that entry, and the rest of its cell follows even after `stop_n` returns low. The next start-of-cell entry is held again.
- R4: With `halt_n` low, `fifo_en` high and bypass off, no FIFO read occurs and the fill character is sent.
- R5: With `enc_bypass` high, `halt_n` and the start-of-cell flags are ignored, and a low `stop_n` blocks reads the way a low `halt_n` does when bypass is off.
- R6: A 0→1 transition on `intr` produces exactly one character with `ch_special`=1 and `ch_out`=RISE_CODE (default 8'h1C), and data flow resumes after it.
- R7: A 1→0 transition on `intr` produces exactly one character with `ch_special`=1 and `ch_out`=FALL_CODE (default 8'h3C).
- R8: An interrupt character defers the data character of its slot. All entries still leave in FIFO order, and none is lost or repeated.
- R9: When the FIFO is empty, `fifo_rd` stays low and the fill character (`ch_special`=1, `ch_out`=FILL_CODE, default 8'hA5) is sent.
- R10: Control inputs pass through one register: a change on `halt_n` before a clock edge affects `fifo_rd` only after that edge.
- R11: While reset is active, `ch_valid` and `fifo_rd` are 0. After reset, `ch_valid` is 1 on every clock.
- R12: An entry read in one cycle appears in the next cycle with `ch_special`=0 and `ch_out` equal to its payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | Enables the stop, halt and interrupt controls |
| enc_bypass | input | 1 | Encoder bypass: stop acts as halt, flags ignored |
| stop_n | input | 1 | Active-low cell-boundary stop |
| halt_n | input | 1 | Active-low immediate halt |
| intr | input | 1 | Edge-sensitive interrupt request |
| fifo_empty | input | 1 | FIFO has no entry |
| fifo_soc | input | 1 | Start-of-cell flag of head entry |
| fifo_data | input | DATA_W | Payload of head entry |
| fifo_rd | output | 1 | Pops the head entry this cycle |
| ch_out | output | DATA_W | Outgoing character or special code |
| ch_special | output | 1 | 1 = special code, 0 = data |
| ch_valid | output | 1 | Character slot valid |

## Verification
The bench builds the controller with its defaults: an 8-bit payload, the fill, rise and fall codes 8'hA5, 8'h1C and 8'h3C, and a two-stage reset release. With 8-bit payloads, each FIFO entry can carry its own index, so a single pass over the output stream shows whether any entry was reordered, lost or repeated around held cells and injected interrupts. The three distinct codes let each special slot be attributed to fill, rising edge or falling edge. The two-stage release puts a known gap between reset and the first read.

// File: rtl/txfc_pkg.sv
package txfc_pkg;
  typedef enum logic [1:0] {
    SRC_FILL = 2'd0,
    SRC_DATA = 2'd1,
    SRC_RISE = 2'd2,
    SRC_FALL = 2'd3
  } txfc_src_e;

  localparam int unsigned NUM_POL = 2;  // interrupt polarities: 0 rise, 1 fall
endpackage

// File: rtl/txfc_ctl_sync.sv
module txfc_ctl_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_n,
  input  logic halt_n,
  input  logic intr,
  output logic stop_q,
  output logic halt_q,
  output logic [1:0] edge_evt
);
  logic intr_q, intr_d;
  logic stop_nx, halt_nx, intr_nx, intr_dnx;

  always_comb begin
    stop_nx  = stop_n;
    halt_nx  = halt_n;
    intr_nx  = intr;
    intr_dnx = intr_q;
  end

  // controls reset to their asserted level so nothing is read before sampling
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      halt_q <= 1'b0;
      intr_q <= 1'b0;
      intr_d <= 1'b0;
    end else begin
      stop_q <= stop_nx;
      halt_q <= halt_nx;
      intr_q <= intr_nx;
      intr_d <= intr_dnx;
    end
  end

  assign edge_evt[0] = intr_q & ~intr_d;
  assign edge_evt[1] = ~intr_q & intr_d;
endmodule

// File: rtl/txfc_int_queue.sv
module txfc_int_queue
  import txfc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [NUM_POL-1:0] evt,
  input  logic [NUM_POL-1:0] take,
  output logic [NUM_POL-1:0] pend
);
  for (genvar p = 0; p < NUM_POL; p++) begin : g_pol
    logic pend_nx;

    always_comb begin
      pend_nx = pend[p];
      if (!enable)     pend_nx = 1'b0;
      else if (evt[p]) pend_nx = 1'b1;
      else if (take[p]) pend_nx = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend[p] <= 1'b0;
      else        pend[p] <= pend_nx;
    end
  end
endmodule

// File: rtl/txfc_slot_sel.sv
module txfc_slot_sel
  import txfc_pkg::*;
(
  input  logic               run,
  input  logic               fifo_en,
  input  logic               enc_bypass,
  input  logic               stop_q,
  input  logic               halt_q,
  input  logic [NUM_POL-1:0] pend,
  input  logic               fifo_empty,
  input  logic               fifo_soc,
  output txfc_src_e          src,
  output logic               rd,
  output logic [NUM_POL-1:0] take
);
  logic halt_eff, cell_gate;

  always_comb begin
    halt_eff  = enc_bypass ? ~stop_q : ~halt_q;
    cell_gate = ~enc_bypass & fifo_soc & ~stop_q;
    src  = SRC_FILL;
    rd   = 1'b0;
    take = '0;
    if (!run) begin
      src = SRC_FILL;
    end else if (!fifo_en) begin
      if (!fifo_empty) begin
        src = SRC_DATA;
        rd  = 1'b1;
      end
    end else if (pend[0]) begin
      src     = SRC_RISE;
      take[0] = 1'b1;
    end else if (pend[1]) begin
      src     = SRC_FALL;
      take[1] = 1'b1;
    end else if (!halt_eff && !fifo_empty && !cell_gate) begin
      src = SRC_DATA;
      rd  = 1'b1;
    end
  end
endmodule

// File: rtl/txflow_ctrl.sv
module txflow_ctrl
  import txfc_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned RST_STAGES = 2,
  parameter logic [DATA_W-1:0] FILL_CODE = DATA_W'('hA5),
  parameter logic [DATA_W-1:0] RISE_CODE = DATA_W'('h1C),
  parameter logic [DATA_W-1:0] FALL_CODE = DATA_W'('h3C)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              enc_bypass,
  input  logic              stop_n,
  input  logic              halt_n,
  input  logic              intr,
  input  logic              fifo_empty,
  input  logic              fifo_soc,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              fifo_rd,
  output logic [DATA_W-1:0] ch_out,
  output logic              ch_special,
  output logic              ch_valid
);
  localparam int unsigned RS_MSB = RST_STAGES - 1;

  // reset: asserted asynchronously, released through RST_STAGES flops (>= 2)
  logic [RS_MSB:0] rst_pipe;
  logic            rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RS_MSB-1:0], 1'b1};
  end
  assign rst_n_s = rst_pipe[RS_MSB];

  logic               stop_q, halt_q;
  logic [NUM_POL-1:0] edge_evt, pend, take;
  txfc_src_e          src;
  logic               rd;

  txfc_ctl_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .stop_n   (stop_n),
    .halt_n   (halt_n),
    .intr     (intr),
    .stop_q   (stop_q),
    .halt_q   (halt_q),
    .edge_evt (edge_evt)
  );

  txfc_int_queue u_intq (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .enable (fifo_en),
    .evt    (edge_evt),
    .take   (take),
    .pend   (pend)
  );

  txfc_slot_sel u_sel (
    .run        (ch_valid),
    .fifo_en    (fifo_en),
    .enc_bypass (enc_bypass),
    .stop_q     (stop_q),
    .halt_q     (halt_q),
    .pend       (pend),
    .fifo_empty (fifo_empty),
    .fifo_soc   (fifo_soc),
    .src        (src),
    .rd         (rd),
    .take       (take)
  );

  assign fifo_rd = rd;

  // output stage: next-state then register
  logic [DATA_W-1:0] out_nx;
  logic              spec_nx;

  always_comb begin
    unique case (src)
      SRC_DATA: begin out_nx = fifo_data; spec_nx = 1'b0; end
      SRC_RISE: begin out_nx = RISE_CODE; spec_nx = 1'b1; end
      SRC_FALL: begin out_nx = FALL_CODE; spec_nx = 1'b1; end
      default:  begin out_nx = FILL_CODE; spec_nx = 1'b1; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ch_out     <= FILL_CODE;
      ch_special <= 1'b1;
      ch_valid   <= 1'b0;
    end else begin
      ch_out     <= out_nx;
      ch_special <= spec_nx;
      ch_valid   <= 1'b1;
    end
  end
endmodule

// File: rtl/txflow_ctrl_chk.sv
module txflow_ctrl_chk #(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] RISE_CODE = DATA_W'('h1C)
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic              fifo_en,
  input logic              enc_bypass,
  input logic              stop_n,
  input logic              halt_n,
  input logic              fifo_empty,
  input logic [DATA_W-1:0] fifo_data,
  input logic              fifo_rd,
  input logic [DATA_W-1:0] ch_out,
  input logic              ch_special,
  input logic              ch_valid
);
  AST_RD_ONLY_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n_s)
    fifo_rd |-> !fifo_empty);  // R9

  AST_HALT_BLOCKS_READ: assert property (@(posedge clk) disable iff (!rst_n_s)
    (fifo_en && !enc_bypass && !$past(halt_n)) |-> !fifo_rd);  // R4

  AST_BYPASS_STOP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n_s)
    (fifo_en && enc_bypass && !$past(stop_n)) |-> !fifo_rd);  // R5

  AST_READ_SHOWS_DATA: assert property (@(posedge clk) disable iff (!rst_n_s)
    $past(fifo_rd) |-> (ch_valid && !ch_special && ch_out == $past(fifo_data)));  // R12

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ch_special && ch_out == RISE_CODE) |=> !(ch_special && ch_out == RISE_CODE));  // R6

  AST_VALID_RUNNING: assert property (@(posedge clk) disable iff (!rst_n_s)
    $past(rst_n_s) |-> ch_valid);  // R11
endmodule

bind txflow_ctrl txflow_ctrl_chk #(.DATA_W(DATA_W), .RISE_CODE(RISE_CODE)) chk_i (
  .clk        (clk),
  .rst_n_s    (rst_n_s),
  .fifo_en    (fifo_en),
  .enc_bypass (enc_bypass),
  .stop_n     (stop_n),
  .halt_n     (halt_n),
  .fifo_empty (fifo_empty),
  .fifo_data  (fifo_data),
  .fifo_rd    (fifo_rd),
  .ch_out     (ch_out),
  .ch_special (ch_special),
  .ch_valid   (ch_valid)
);

// File: tb/txflow_ctrl_tb_top.sv
module txflow_ctrl_tb_top;
  localparam logic [7:0] FILL = 8'hA5;
  localparam logic [7:0] RISE = 8'h1C;
  localparam logic [7:0] FALL = 8'h3C;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, fifo_en, enc_bypass, stop_n, halt_n, intr;
  logic       fifo_empty, fifo_soc, fifo_rd, ch_special, ch_valid;
  logic [7:0] fifo_data, ch_out;

  // bench FIFO model (first word fall through)
  logic [8:0] fmem [0:31];
  logic [5:0] rp, wp;
  logic       fifo_clr;

  always @(posedge clk) begin
    if (fifo_clr) rp <= 6'd0;
    else if (fifo_rd && !fifo_empty) rp <= rp + 6'd1;
  end
  assign fifo_empty = (rp == wp);
  assign fifo_data  = fmem[rp[4:0]][7:0];
  assign fifo_soc   = fmem[rp[4:0]][8];

  txflow_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .enc_bypass(enc_bypass),
    .stop_n(stop_n), .halt_n(halt_n), .intr(intr), .fifo_empty(fifo_empty),
    .fifo_soc(fifo_soc), .fifo_data(fifo_data), .fifo_rd(fifo_rd),
    .ch_out(ch_out), .ch_special(ch_special), .ch_valid(ch_valid)
  );

  int nchk = 0;
  int nfail = 0;
  logic [7:0] cap_ch [0:63];
  logic       cap_sp [0:63];
  int ncap;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start(input logic en, input logic byp, input logic stp,
                       input logic hlt, input int n, input logic [31:0] soc);
    @(negedge clk);
    rst_n = 1'b0; fifo_clr = 1'b1; intr = 1'b0;
    fifo_en = en; enc_bypass = byp; stop_n = stp; halt_n = hlt;
    for (int i = 0; i < 32; i++) fmem[i] = {soc[i], 8'h40 + 8'(i)};
    wp = 6'(n);
    repeat (2) @(negedge clk);
    rst_n = 1'b1; fifo_clr = 1'b0;
  endtask

  task automatic capture(input int n);
    ncap = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cap_ch[k] = ch_out; cap_sp[k] = ch_special; ncap++;
    end
  endtask

  // data count, order errors, stray specials in the capture
  task automatic scan(output int nd, output int bad, output int nrise,
                      output int nfall, output int nodd);
    nd = 0; bad = 0; nrise = 0; nfall = 0; nodd = 0;
    for (int k = 0; k < ncap; k++) begin
      if (!cap_sp[k]) begin
        if (cap_ch[k] != 8'h40 + 8'(nd)) bad++;
        nd++;
      end else if (cap_ch[k] == RISE) nrise++;
      else if (cap_ch[k] == FALL) nfall++;
      else if (cap_ch[k] != FILL) nodd++;
    end
  endtask

  typedef struct packed {
    logic       en;
    logic       byp;
    logic       stp;
    logic       hlt;
    logic [3:0] n;
    logic [7:0] soc;
    logic [3:0] exp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VT [NV] = '{
    '{1'b1, 1'b0, 1'b1, 1'b1, 4'd4, 8'b0101, 4'd4},  // R12 free flow
    '{1'b1, 1'b0, 1'b0, 1'b1, 4'd4, 8'b0101, 4'd0},  // R2 head is cell start
    '{1'b1, 1'b0, 1'b0, 1'b1, 4'd4, 8'b0100, 4'd2},  // R2 drain to boundary
    '{1'b1, 1'b0, 1'b0, 1'b1, 4'd4, 8'b0000, 4'd4},  // R2 no boundary
    '{1'b1, 1'b0, 1'b1, 1'b0, 4'd4, 8'b0000, 4'd0},  // R4 halt
    '{1'b0, 1'b0, 1'b0, 1'b0, 4'd4, 8'b0101, 4'd4},  // R1 controls ignored
    '{1'b1, 1'b1, 1'b0, 1'b1, 4'd4, 8'b0100, 4'd0},  // R5 stop acts as halt
    '{1'b1, 1'b1, 1'b1, 1'b0, 4'd4, 8'b0101, 4'd4},  // R5 halt and flags ignored
    '{1'b1, 1'b0, 1'b1, 1'b1, 4'd0, 8'b0000, 4'd0}   // R9 empty FIFO
  };

  initial begin
    int nd, bad, nr, nf, no, ri, fi;
    rst_n = 1'b0; fifo_clr = 1'b1; fifo_en = 1'b0; enc_bypass = 1'b0;
    stop_n = 1'b1; halt_n = 1'b1; intr = 1'b0; wp = 6'd0;

    for (int v = 0; v < NV; v++) begin
      start(VT[v].en, VT[v].byp, VT[v].stp, VT[v].hlt, int'(VT[v].n), 32'(VT[v].soc));
      capture(16);
      scan(nd, bad, nr, nf, no);
      chk(nd == int'(VT[v].exp), $sformatf("R1/R2/R4/R5/R9/R12 row %0d data count", v), nd, int'(VT[v].exp));
      chk(bad == 0 && (nr + nf + no) == 0, $sformatf("R12 row %0d order/fill", v), bad + nr + nf + no, 0);
    end

    // R11: reset state with a readable FIFO and controls disabled
    @(negedge clk);
    rst_n = 1'b0; fifo_clr = 1'b1; fifo_en = 1'b0; wp = 6'd4;
    repeat (2) @(negedge clk);
    chk(ch_valid == 1'b0, "R11 valid in reset", int'(ch_valid), 0);
    chk(fifo_rd == 1'b0, "R11 rd in reset", int'(fifo_rd), 0);
    rst_n = 1'b1; fifo_clr = 1'b0;
    repeat (4) @(negedge clk);
    chk(ch_valid == 1'b1, "R11 valid after reset", int'(ch_valid), 1);

    // R3: single-clock stop release passes exactly one whole cell
    start(1'b1, 1'b0, 1'b0, 1'b1, 5, 32'b01001);
    capture(8);
    scan(nd, bad, nr, nf, no);
    chk(nd == 0, "R3 held before release", nd, 0);
    stop_n = 1'b1;
    @(negedge clk);
    stop_n = 1'b0;
    capture(12);
    scan(nd, bad, nr, nf, no);
    chk(nd == 3 && bad == 0, "R3 whole cell released", nd, 3);
    chk(rp == 6'd3, "R3 next cell held", int'(rp), 3);

    // R10 / R4: halt takes effect one edge after the input changes
    start(1'b1, 1'b0, 1'b1, 1'b1, 20, 32'd0);
    repeat (5) @(negedge clk);
    halt_n = 1'b0;
    #1;
    chk(fifo_rd == 1'b1, "R10 rd before sampling edge", int'(fifo_rd), 1);
    @(negedge clk);
    chk(fifo_rd == 1'b0, "R10 rd after sampling edge", int'(fifo_rd), 0);
    capture(4);
    scan(nd, bad, nr, nf, no);
    chk(nd == 0 && no == 0, "R4 fill while halted", nd, 0);

    // R6 R7 R8: interrupt edges injected into a flowing stream
    start(1'b1, 1'b0, 1'b1, 1'b1, 12, 32'd0);
    ncap = 0; ri = -1; fi = -1;
    for (int k = 0; k < 26; k++) begin
      @(negedge clk);
      cap_ch[k] = ch_out; cap_sp[k] = ch_special; ncap++;
      if (ch_special && ch_out == RISE && ri < 0) ri = k;
      if (ch_special && ch_out == FALL && fi < 0) fi = k;
      if (k == 4) intr = 1'b1;
      if (k == 9) intr = 1'b0;
    end
    scan(nd, bad, nr, nf, no);
    chk(nr == 1, "R6 one rise character", nr, 1);
    chk(nf == 1, "R7 one fall character", nf, 1);
    chk(nd == 12 && bad == 0, "R8 all data in order", nd, 12);
    chk(ri >= 0 && fi > ri + 1 && !cap_sp[ri + 1], "R6 data resumes after rise", fi - ri, 2);
    chk(fifo_rd == 1'b0 && ch_special && ch_out == FILL, "R9 drained gives fill", int'(ch_out), int'(FILL));

    // R1: interrupt edges ignored while controls are disabled
    start(1'b0, 1'b0, 1'b1, 1'b1, 6, 32'd0);
    ncap = 0;
    for (int k = 0; k < 14; k++) begin
      @(negedge clk);
      cap_ch[k] = ch_out; cap_sp[k] = ch_special; ncap++;
      if (k == 3) intr = 1'b1;
      if (k == 7) intr = 1'b0;
    end
    scan(nd, bad, nr, nf, no);
    chk(nr + nf == 0, "R1 no interrupt characters", nr + nf, 0);
    chk(nd == 6 && bad == 0, "R1 data unaffected", nd, 6);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk + 1, nfail + 1);
    $finish;
  end
endmodule